// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. Each entry holds a virtual page number, a physical page number, a 12-bit context tag and a global flag. A lookup presents a virtual page and receives a hit or miss one cycle later, with the physical page on a hit. After a miss, the surrounding logic resolves the translation and installs it through the fill port. The new entry is tagged with the context that is current at that moment.

The current context comes from writes to a page-table base register. A separate control register holds an enable bit for context tagging. When tagging is off, every base-register write empties the whole cache. When tagging is on, a base-register write only switches the current context, so translations of several contexts can sit in the cache together. Single contexts are removed on demand, either through an invalidate command or through a flag in the base-register value. Entries marked global serve every context and survive both kinds of selective removal.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup request returns its result exactly one cycle later: `lkp_valid_o` pulses high for one cycle, and exactly one of `lkp_hit_o` and `lkp_miss_o` is high with it. While no request is issued, `lkp_valid_o`, `lkp_hit_o` and `lkp_miss_o` stay low and `lkp_ppn_o` keeps its last value.
- R2: After reset, every entry is invalid, the current context is 0 and tagging is off, so every lookup misses until the first fill.
- R3: A lookup hits when a valid entry holds the requested virtual page and either has its global flag set or carries a tag equal to the current context. The physical page of that entry is returned. Otherwise the lookup misses.
- R4: A fill tags its entry with the context that is current in the fill cycle. A non-global entry filled under one context misses after a switch to another context, and hits again after a switch back.
- R5: A control-register write with bit 17 set to 1 turns tagging on. A write with bit 17 set to 0 turns it off.
- R6: While tagging is off, a base-register write invalidates all entries, including global ones.
- R7: While tagging is on, a base-register write sets the current context to bits [11:0] of the written value and leaves every entry in place.
- R8: While tagging is on, a base-register write with bit 63 set invalidates every non-global entry tagged with the newly written context. Entries of other contexts and global entries are kept.
- R9: An invalidate-by-context command invalidates every non-global entry whose tag equals `inv_ctx_i`. Global entries and entries of other contexts are kept.
- R10: A fill whose virtual page matches a valid entry under the current context overwrites that entry. Otherwise the fill takes the lowest-numbered invalid entry. When all entries are valid, a round-robin pointer picks the victim; the pointer starts at entry 0 and advances by one after each such replacement.
- R11: A fill or an invalidation issued in the same cycle as a lookup does not change that lookup's result. It takes effect for the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_req_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Virtual page to translate |
| lkp_valid_o | output | 1 | Lookup result valid, one cycle after the request |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_miss_o | output | 1 | Lookup miss |
| lkp_ppn_o | output | PPN_W | Translated physical page |
| fill_req_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Virtual page of the fill |
| fill_ppn_i | input | PPN_W | Physical page of the fill |
| fill_glb_i | input | 1 | Global flag of the fill |
| ptb_we_i | input | 1 | Page-table base register write strobe |
| ptb_data_i | input | PTB_W | Base value: context in [11:0], context invalidate in bit 63 |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_data_i | input | CTL_W | Control value: tagging enable in bit 17 |
| inv_ctx_req_i | input | 1 | Invalidate-by-context command |
| inv_ctx_i | input | CTX_W | Context to invalidate |

## Verification
The checker keeps its own copy of the tagging-enable bit, taken from control-register writes, and expects no other agent to change that state. Its flush property also assumes that no fill arrives in the same cycle as the flushing base-register write. The bench keeps to these assumptions: it issues one operation per cycle, except in the deliberate same-cycle cases, and those pair a lookup with a fill or an invalidate and never a fill with a flush. The empty-after-reset property relies on every valid entry having come from a fill, which holds because the fill port is the only way to load an entry.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  typedef enum logic [1:0] {
    VIC_HIT  = 2'd0,
    VIC_FREE = 2'd1,
    VIC_RR   = 2'd2
  } vic_src_e;
endpackage

// File: rtl/ctx_tlb_state.sv
module ctx_tlb_state #(
  parameter int CTX_W      = 12,
  parameter int PTB_W      = 64,
  parameter int CTL_W      = 32,
  parameter int TAG_EN_BIT = 17,
  parameter int INV_BIT    = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptb_we_i,
  input  logic [PTB_W-1:0] ptb_data_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_data_i,
  output logic [CTX_W-1:0] cur_ctx_o,
  output logic             tag_en_o,
  output logic             flush_all_o,
  output logic             inv_new_o,
  output logic [CTX_W-1:0] new_ctx_o
);
  logic [CTX_W-1:0] ctx_q;
  logic             tag_en_q;
  logic             unused_bits;

  assign unused_bits = ^{ptb_data_i, ctl_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q    <= '0;
      tag_en_q <= 1'b0;
    end else begin
      if (ptb_we_i) ctx_q <= ptb_data_i[CTX_W-1:0];
      if (ctl_we_i) tag_en_q <= ctl_data_i[TAG_EN_BIT];
    end
  end

  assign cur_ctx_o   = ctx_q;
  assign tag_en_o    = tag_en_q;
  assign new_ctx_o   = ptb_data_i[CTX_W-1:0];
  assign flush_all_o = ptb_we_i & ~tag_en_q;
  assign inv_new_o   = ptb_we_i & tag_en_q & ptb_data_i[INV_BIT];
endmodule

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int CTX_W = 12,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             vld_i [N],
  input  logic             glb_i [N],
  input  logic [CTX_W-1:0] ctx_i [N],
  input  logic [VPN_W-1:0] vpn_i [N],
  input  logic [VPN_W-1:0] key_vpn_i,
  input  logic [CTX_W-1:0] key_ctx_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_i[g] && (vpn_i[g] == key_vpn_i) &&
                        (glb_i[g] || (ctx_i[g] == key_ctx_i));
  end

  assign any_o = |hit_vec;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim
  import ctx_tlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             vld_i [N],
  input  logic             match_any_i,
  input  logic [IDX_W-1:0] match_idx_i,
  output logic [IDX_W-1:0] idx_o,
  output vic_src_e         src_o
);
  logic [N-1:0]     free_vec;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;

  for (genvar g = 0; g < N; g++) begin : g_free
    assign free_vec[g] = ~vld_i[g];
  end

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (match_any_i) begin
      idx_o = match_idx_i;
      src_o = VIC_HIT;
    end else if (|free_vec) begin
      idx_o = free_idx;
      src_o = VIC_FREE;
    end else begin
      idx_o = rr_q;
      src_o = VIC_RR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc_i && src_o == VIC_RR) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 20,
  parameter int CTX_W      = 12,
  parameter int PTB_W      = 64,
  parameter int CTL_W      = 32,
  parameter int TAG_EN_BIT = 17,
  parameter int INV_BIT    = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_req_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic             lkp_valid_o,
  output logic             lkp_hit_o,
  output logic             lkp_miss_o,
  output logic [PPN_W-1:0] lkp_ppn_o,
  input  logic             fill_req_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_glb_i,
  input  logic             ptb_we_i,
  input  logic [PTB_W-1:0] ptb_data_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_data_i,
  input  logic             inv_ctx_req_i,
  input  logic [CTX_W-1:0] inv_ctx_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic             vld_q [ENTRIES];
  logic             glb_q [ENTRIES];
  logic [CTX_W-1:0] tag_q [ENTRIES];
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];

  logic [CTX_W-1:0] cur_ctx, new_ctx;
  logic             tag_en, flush_all, inv_new;
  logic             lk_any, fl_any;
  logic [IDX_W-1:0] lk_idx, fl_idx, vic_idx;
  vic_src_e         vic_src;

  logic             res_vld_q, res_hit_q;
  logic [PPN_W-1:0] res_ppn_q;
  logic             unused_sig;

  assign unused_sig = tag_en ^ vic_src[0] ^ vic_src[1];

  ctx_tlb_state #(
    .CTX_W(CTX_W), .PTB_W(PTB_W), .CTL_W(CTL_W),
    .TAG_EN_BIT(TAG_EN_BIT), .INV_BIT(INV_BIT)
  ) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ptb_we_i    (ptb_we_i),
    .ptb_data_i  (ptb_data_i),
    .ctl_we_i    (ctl_we_i),
    .ctl_data_i  (ctl_data_i),
    .cur_ctx_o   (cur_ctx),
    .tag_en_o    (tag_en),
    .flush_all_o (flush_all),
    .inv_new_o   (inv_new),
    .new_ctx_o   (new_ctx)
  );

  ctx_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_lkp_match (
    .vld_i     (vld_q),
    .glb_i     (glb_q),
    .ctx_i     (tag_q),
    .vpn_i     (vpn_q),
    .key_vpn_i (lkp_vpn_i),
    .key_ctx_i (cur_ctx),
    .any_o     (lk_any),
    .idx_o     (lk_idx)
  );

  ctx_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_fill_match (
    .vld_i     (vld_q),
    .glb_i     (glb_q),
    .ctx_i     (tag_q),
    .vpn_i     (vpn_q),
    .key_vpn_i (fill_vpn_i),
    .key_ctx_i (cur_ctx),
    .any_o     (fl_any),
    .idx_o     (fl_idx)
  );

  ctx_tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (fill_req_i),
    .vld_i       (vld_q),
    .match_any_i (fl_any),
    .match_idx_i (fl_idx),
    .idx_o       (vic_idx),
    .src_o       (vic_src)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic kill;
    logic take;

    assign take = fill_req_i && (vic_idx == IDX_W'(g));
    // fill wins over a same-cycle invalidation of its own slot
    assign kill = flush_all ||
                  (inv_ctx_req_i && !glb_q[g] && (tag_q[g] == inv_ctx_i)) ||
                  (inv_new && !glb_q[g] && (tag_q[g] == new_ctx));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        glb_q[g] <= 1'b0;
        tag_q[g] <= '0;
        vpn_q[g] <= '0;
        ppn_q[g] <= '0;
      end else if (take) begin
        vld_q[g] <= 1'b1;
        glb_q[g] <= fill_glb_i;
        tag_q[g] <= cur_ctx;
        vpn_q[g] <= fill_vpn_i;
        ppn_q[g] <= fill_ppn_i;
      end else if (kill) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_q <= 1'b0;
      res_hit_q <= 1'b0;
      res_ppn_q <= '0;
    end else begin
      res_vld_q <= lkp_req_i;
      if (lkp_req_i) begin
        res_hit_q <= lk_any;
        res_ppn_q <= lk_any ? ppn_q[lk_idx] : '0;
      end
    end
  end

  assign lkp_valid_o = res_vld_q;
  assign lkp_hit_o   = res_vld_q & res_hit_q;
  assign lkp_miss_o  = res_vld_q & ~res_hit_q;
  assign lkp_ppn_o   = res_ppn_q;
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int PPN_W      = 20,
  parameter int CTL_W      = 32,
  parameter int TAG_EN_BIT = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_req_i,
  input logic             fill_req_i,
  input logic             ptb_we_i,
  input logic             ctl_we_i,
  input logic [CTL_W-1:0] ctl_data_i,
  input logic             lkp_valid_o,
  input logic             lkp_hit_o,
  input logic             lkp_miss_o,
  input logic [PPN_W-1:0] lkp_ppn_o
);
  logic tag_sh_q;
  logic filled_q;
  logic unused_ctl;

  assign unused_ctl = ^ctl_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_sh_q <= 1'b0;
      filled_q <= 1'b0;
    end else begin
      if (ctl_we_i) tag_sh_q <= ctl_data_i[TAG_EN_BIT];
      if (fill_req_i) filled_q <= 1'b1;
    end
  end

  assert_req_gives_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> lkp_valid_o && $countones({lkp_hit_o, lkp_miss_o}) == 1);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> !lkp_valid_o && !lkp_hit_o && !lkp_miss_o && $stable(lkp_ppn_o));

  assert_empty_after_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && !filled_q) |=> !lkp_hit_o);

  assert_flush_untagged_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptb_we_i && !tag_sh_q && !fill_req_i) ##1 lkp_req_i |=> !lkp_hit_o);
endmodule

bind ctx_tlb ctx_tlb_chk #(
  .PPN_W(PPN_W), .CTL_W(CTL_W), .TAG_EN_BIT(TAG_EN_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_req_i   (lkp_req_i),
  .fill_req_i  (fill_req_i),
  .ptb_we_i    (ptb_we_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_data_i  (ctl_data_i),
  .lkp_valid_o (lkp_valid_o),
  .lkp_hit_o   (lkp_hit_o),
  .lkp_miss_o  (lkp_miss_o),
  .lkp_ppn_o   (lkp_ppn_o)
);

// File: tb/ctx_tlb_tb.sv
`timescale 1ns/1ps
module ctx_tlb_tb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int CTX_W = 12;
  localparam int PTB_W = 64;
  localparam int CTL_W = 32;
  localparam int NENT  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lkp_req_i = 1'b0;
  logic [VPN_W-1:0] lkp_vpn_i = '0;
  logic             lkp_valid_o, lkp_hit_o, lkp_miss_o;
  logic [PPN_W-1:0] lkp_ppn_o;
  logic             fill_req_i = 1'b0;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [PPN_W-1:0] fill_ppn_i = '0;
  logic             fill_glb_i = 1'b0;
  logic             ptb_we_i = 1'b0;
  logic [PTB_W-1:0] ptb_data_i = '0;
  logic             ctl_we_i = 1'b0;
  logic [CTL_W-1:0] ctl_data_i = '0;
  logic             inv_ctx_req_i = 1'b0;
  logic [CTX_W-1:0] inv_ctx_i = '0;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ctx_tlb u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lkp_req_i(lkp_req_i), .lkp_vpn_i(lkp_vpn_i),
    .lkp_valid_o(lkp_valid_o), .lkp_hit_o(lkp_hit_o),
    .lkp_miss_o(lkp_miss_o), .lkp_ppn_o(lkp_ppn_o),
    .fill_req_i(fill_req_i), .fill_vpn_i(fill_vpn_i),
    .fill_ppn_i(fill_ppn_i), .fill_glb_i(fill_glb_i),
    .ptb_we_i(ptb_we_i), .ptb_data_i(ptb_data_i),
    .ctl_we_i(ctl_we_i), .ctl_data_i(ctl_data_i),
    .inv_ctx_req_i(inv_ctx_req_i), .inv_ctx_i(inv_ctx_i)
  );

  // {is_fill, glb, exp_hit, vpn, ppn}
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 20'h00100, 20'h00A00},
    {1'b1, 1'b1, 1'b0, 20'h00200, 20'h00B00},
    {1'b0, 1'b0, 1'b1, 20'h00100, 20'h00A00},
    {1'b0, 1'b0, 1'b1, 20'h00200, 20'h00B00},
    {1'b0, 1'b0, 1'b0, 20'h00300, 20'h00000},
    {1'b1, 1'b0, 1'b0, 20'h00100, 20'h00A11},
    {1'b0, 1'b0, 1'b1, 20'h00100, 20'h00A11}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                      input logic g);
    @(negedge clk_i);
    fill_req_i = 1'b1; fill_vpn_i = v; fill_ppn_i = p; fill_glb_i = g;
    @(negedge clk_i);
    fill_req_i = 1'b0; fill_glb_i = 1'b0;
  endtask

  task automatic ptb(input logic [CTX_W-1:0] c, input logic inv);
    @(negedge clk_i);
    ptb_we_i = 1'b1;
    ptb_data_i = '0;
    ptb_data_i[CTX_W-1:0] = c;
    ptb_data_i[63] = inv;
    @(negedge clk_i);
    ptb_we_i = 1'b0;
  endtask

  task automatic ctl(input logic en);
    @(negedge clk_i);
    ctl_we_i = 1'b1;
    ctl_data_i = '0;
    ctl_data_i[17] = en;
    @(negedge clk_i);
    ctl_we_i = 1'b0;
  endtask

  task automatic inv_ctx(input logic [CTX_W-1:0] c);
    @(negedge clk_i);
    inv_ctx_req_i = 1'b1; inv_ctx_i = c;
    @(negedge clk_i);
    inv_ctx_req_i = 1'b0;
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] v,
                      input logic eh, input logic [PPN_W-1:0] ep);
    @(negedge clk_i);
    lkp_req_i = 1'b1; lkp_vpn_i = v;
    @(negedge clk_i);
    lkp_req_i = 1'b0;
    chk(req, "hit", 32'(lkp_hit_o), 32'(eh));
    chk(req, "miss", 32'(lkp_miss_o), 32'(!eh));
    if (eh) chk(req, "ppn", 32'(lkp_ppn_o), 32'(ep));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R2", "valid_reset", 32'(lkp_valid_o), 0);
    look("R2", 20'h00100, 1'b0, '0);
    @(negedge clk_i);
    chk("R1", "idle_valid", 32'(lkp_valid_o), 0);
    chk("R1", "idle_hit", 32'(lkp_hit_o), 0);

    // R3 R10: fill, lookup, in-place overwrite
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) fill(VEC[i][39:20], VEC[i][19:0], VEC[i][41]);
      else look("R3", VEC[i][39:20], VEC[i][40], VEC[i][19:0]);
    end

    // R5 R7 R4: tagging on, context switch keeps entries
    ctl(1'b1);
    ptb(12'd5, 1'b0);
    look("R4", 20'h00100, 1'b0, '0);
    look("R3", 20'h00200, 1'b1, 20'h00B00);
    ptb(12'd0, 1'b0);
    look("R7", 20'h00100, 1'b1, 20'h00A11);

    fill(20'h00400, 20'h00C00, 1'b0);
    ptb(12'd7, 1'b0);
    fill(20'h00400, 20'h00D00, 1'b0);
    look("R4", 20'h00400, 1'b1, 20'h00D00);
    ptb(12'd0, 1'b0);
    look("R4", 20'h00400, 1'b1, 20'h00C00);

    // R9
    inv_ctx(12'd7);
    look("R9", 20'h00400, 1'b1, 20'h00C00);
    ptb(12'd7, 1'b0);
    look("R9", 20'h00400, 1'b0, '0);
    look("R9", 20'h00200, 1'b1, 20'h00B00);

    // R8
    fill(20'h00500, 20'h00E00, 1'b0);
    ptb(12'd0, 1'b0);
    ptb(12'd7, 1'b1);
    look("R8", 20'h00500, 1'b0, '0);
    look("R8", 20'h00200, 1'b1, 20'h00B00);
    ptb(12'd0, 1'b0);
    look("R8", 20'h00100, 1'b1, 20'h00A11);

    // R11: same-cycle fill and lookup
    @(negedge clk_i);
    lkp_req_i = 1'b1; lkp_vpn_i = 20'h00600;
    fill_req_i = 1'b1; fill_vpn_i = 20'h00600; fill_ppn_i = 20'h00F00;
    @(negedge clk_i);
    lkp_req_i = 1'b0; fill_req_i = 1'b0;
    chk("R11", "fill_same_cycle_hit", 32'(lkp_hit_o), 0);
    look("R11", 20'h00600, 1'b1, 20'h00F00);
    // R11: same-cycle invalidate and lookup
    @(negedge clk_i);
    lkp_req_i = 1'b1; lkp_vpn_i = 20'h00600;
    inv_ctx_req_i = 1'b1; inv_ctx_i = 12'd0;
    @(negedge clk_i);
    lkp_req_i = 1'b0; inv_ctx_req_i = 1'b0;
    chk("R11", "inv_same_cycle_hit", 32'(lkp_hit_o), 1);
    look("R11", 20'h00600, 1'b0, '0);

    // R5 R6: tagging off, base write flushes everything
    ctl(1'b0);
    ptb(12'd0, 1'b0);
    look("R6", 20'h00200, 1'b0, '0);
    look("R6", 20'h00400, 1'b0, '0);

    // R10: round-robin replacement
    for (int i = 0; i < NENT; i++) fill(20'h00010 + 20'(i), 20'h00050 + 20'(i), 1'b0);
    fill(20'h00010, 20'h00099, 1'b0);
    look("R10", 20'h00017, 1'b1, 20'h00057);
    look("R10", 20'h00010, 1'b1, 20'h00099);
    fill(20'h00018, 20'h00058, 1'b0);
    look("R10", 20'h00010, 1'b0, '0);
    look("R10", 20'h00011, 1'b1, 20'h00051);
    look("R10", 20'h00018, 1'b1, 20'h00058);
    fill(20'h00019, 20'h00059, 1'b0);
    look("R10", 20'h00011, 1'b0, '0);
    look("R10", 20'h00012, 1'b1, 20'h00052);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule